// File: doc/BRIEF.md
# Programmed IO Configuration Request Engine

This block lets a host processor launch one configuration (or other single-word) request toward a link through a small register file, then collect the outcome. Software fills in a transaction type, a 64-bit target address written as two 32-bit halves, write data and a byte strobe. A write of one to the start register makes the engine capture those fields and present one request on a valid/ready port. It then waits for a single-cycle completion and records the completion code, the returned data and whether the request was non-posted. It raises a done flag and drops start.

The control sequence is a three-state machine. IDLE waits for a launch, which is a write of one to start while no request is outstanding (IDLE to ISSUE). ISSUE holds the request valid until the far side accepts it (ISSUE to WAIT on valid and ready together). WAIT holds until a completion arrives and then records the result (WAIT to IDLE on completion valid). The done flag is gated by a mask bit onto one interrupt line. Software polls for start reading zero and the done flag reading one, or takes the interrupt.

Registers are addressed by a 4-bit word index on the register port. Writes take effect at the clock edge. Reads are combinational from the index.

Top module: `pio_cfg_engine`

## Requirements
- R1: After reset, every register reads zero, no request is presented and the interrupt output is low.
- R2: Index 0 is control, index 4 is write data, index 5 holds the strobe in bits 3:0, and index 7 bit 0 is start. Writing 1 to start while idle presents exactly one request in the cycle after the write. Valid stays high with stable fields until accepted and drops in the cycle after acceptance. The request data equals the write-data register.
- R3: Control bits 3:0 give the issued type and control bit 24 gives the issued window-bypass flag. For the configuration types 0x8, 0x9, 0xA and 0xB, the issued address has bits 1:0 forced to zero. Other types pass the address unchanged.
- R4: The configuration read types 0x8 and 0x9 always issue strobe 4'hF. All other types issue the programmed strobe.
- R5: In the cycle after a completion, start (index 7 bit 0) reads 0 and the done flag (index 8 bit 0) reads 1. The status register (index 1) holds the completion code in bits 9:7, with OK=0, UR=1, CRS=2 and CA=4. Status bit 0 is 1 when the launched type was one of the configuration types 0x8 to 0xB, and 0 otherwise.
- R6: The read-data register (index 6) takes the completion data when the code is OK. For any other code it is loaded with all ones.
- R7: A write to start while a request is outstanding has no effect. Start stays 1 until the completion and no second request follows it.
- R8: The done flag is write-one-to-clear. Writing 1 to index 8 bit 0 clears it, and writing 0 leaves it set.
- R9: The interrupt output is high while the done flag is set and the mask (index 9 bit 0, 1 = masked) is clear. It follows a mask change in the next cycle.
- R10: Index 2 holds address bits 31:0 and index 3 holds bits 63:32 of the issued address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write enable |
| cfg_idx | input | 4 | Register word index for reads and writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_idx |
| req_valid | output | 1 | Request presented |
| req_ready | input | 1 | Request accepted |
| req_type | output | 4 | Issued transaction type |
| req_addr | output | 64 | Issued target address |
| req_data | output | 32 | Issued write data |
| req_strb | output | 4 | Issued byte strobe |
| req_bypass | output | 1 | Skip outbound window translation |
| cpl_valid | input | 1 | Completion present this cycle |
| cpl_status | input | 3 | Completion code |
| cpl_data | input | 32 | Completion data |
| irq | output | 1 | Unmasked done interrupt |

## Verification
The request is due one cycle after the start write. The registers it changes (start, done flag, status, read data) and the interrupt are due one cycle after the clock edge that carries the completion. The interrupt follows a mask write one cycle later. The bench drives all inputs on the falling edge and reads the outputs on the falling edge that follows the edge of interest. Each result is therefore sampled exactly one register stage after its cause.

A table of requests covers each completion code, each configuration type and one posted type, with acceptance delayed by zero to three cycles. During that delay the bench checks that valid is held. Directed cases then cover reset, start writes during a request, the mask, and clearing the done flag.

// File: rtl/pio_cfg_pkg.sv
package pio_cfg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } pio_state_e;

    localparam int IDX_W      = 4;
    localparam int TYPE_W     = 4;
    localparam int CODE_W     = 3;
    localparam int BYPASS_BIT = 24;
    localparam int CODE_LSB   = 7;

    localparam logic [IDX_W-1:0] IDX_CTRL   = 4'd0;
    localparam logic [IDX_W-1:0] IDX_STAT   = 4'd1;
    localparam logic [IDX_W-1:0] IDX_ALO    = 4'd2;
    localparam logic [IDX_W-1:0] IDX_AHI    = 4'd3;
    localparam logic [IDX_W-1:0] IDX_WDATA  = 4'd4;
    localparam logic [IDX_W-1:0] IDX_STRB   = 4'd5;
    localparam logic [IDX_W-1:0] IDX_RDATA  = 4'd6;
    localparam logic [IDX_W-1:0] IDX_START  = 4'd7;
    localparam logic [IDX_W-1:0] IDX_DONE   = 4'd8;
    localparam logic [IDX_W-1:0] IDX_MASK   = 4'd9;

    localparam logic [CODE_W-1:0] CODE_OK = 3'd0;

    function automatic logic is_cfg_type(input logic [TYPE_W-1:0] t);
        return t[3:2] == 2'b10;
    endfunction

    function automatic logic is_cfg_read(input logic [TYPE_W-1:0] t);
        return t[3:1] == 3'b100;
    endfunction

endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
    import pio_cfg_pkg::*;
#(
    parameter int DW = 32,
    localparam int SW = DW / 8,
    localparam int AW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    input  logic              busy,
    input  logic              done,
    input  logic [CODE_W-1:0] done_code,
    input  logic [DW-1:0]     done_data,
    input  logic              done_np,
    output logic              launch,
    output logic [TYPE_W-1:0] ctrl_type,
    output logic              ctrl_bypass,
    output logic [AW-1:0]     addr_q,
    output logic [DW-1:0]     wdata_q,
    output logic [SW-1:0]     strb_q,
    output logic              start_q,
    output logic              done_q,
    output logic [DW-1:0]     rdata_q,
    output logic              irq
);

    logic [CODE_W-1:0] code_q;
    logic              np_q;
    logic              mask_q;

    function automatic logic hit(input logic [IDX_W-1:0] i);
        return wr_en && (idx == i);
    endfunction

    assign launch = hit(IDX_START) && wr_data[0] && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_type   <= '0;
            ctrl_bypass <= 1'b0;
            addr_q      <= '0;
            wdata_q     <= '0;
            strb_q      <= '0;
            mask_q      <= 1'b0;
        end else begin
            if (hit(IDX_CTRL)) begin
                ctrl_type   <= wr_data[TYPE_W-1:0];
                ctrl_bypass <= wr_data[BYPASS_BIT];
            end
            if (hit(IDX_ALO))   addr_q[DW-1:0]  <= wr_data;
            if (hit(IDX_AHI))   addr_q[AW-1:DW] <= wr_data;
            if (hit(IDX_WDATA)) wdata_q         <= wr_data;
            if (hit(IDX_STRB))  strb_q          <= wr_data[SW-1:0];
            if (hit(IDX_MASK))  mask_q          <= wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            code_q  <= '0;
            np_q    <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (done)
                start_q <= 1'b0;
            else if (launch)
                start_q <= 1'b1;

            if (done)
                done_q <= 1'b1;
            else if (hit(IDX_DONE) && wr_data[0])
                done_q <= 1'b0;

            if (done) begin
                code_q  <= done_code;
                np_q    <= done_np;
                rdata_q <= (done_code == CODE_OK) ? done_data : '1;
            end
        end
    end

    assign irq = done_q && !mask_q;

    always_comb begin
        rd_data = '0;
        unique case (idx)
            IDX_CTRL: begin
                rd_data[TYPE_W-1:0] = ctrl_type;
                rd_data[BYPASS_BIT] = ctrl_bypass;
            end
            IDX_STAT: begin
                rd_data[CODE_LSB +: CODE_W] = code_q;
                rd_data[0]                  = np_q;
            end
            IDX_ALO:   rd_data = addr_q[DW-1:0];
            IDX_AHI:   rd_data = addr_q[AW-1:DW];
            IDX_WDATA: rd_data = wdata_q;
            IDX_STRB:  rd_data[SW-1:0] = strb_q;
            IDX_RDATA: rd_data = rdata_q;
            IDX_START: rd_data[0] = start_q;
            IDX_DONE:  rd_data[0] = done_q;
            IDX_MASK:  rd_data[0] = mask_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/pio_cfg_fsm.sv
module pio_cfg_fsm
    import pio_cfg_pkg::*;
#(
    parameter int DW = 32,
    localparam int SW = DW / 8,
    localparam int AW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [TYPE_W-1:0] in_type,
    input  logic              in_bypass,
    input  logic [AW-1:0]     in_addr,
    input  logic [DW-1:0]     in_data,
    input  logic [SW-1:0]     in_strb,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [TYPE_W-1:0] req_type,
    output logic [AW-1:0]     req_addr,
    output logic [DW-1:0]     req_data,
    output logic [SW-1:0]     req_strb,
    output logic              req_bypass,
    input  logic              cpl_valid,
    input  logic [CODE_W-1:0] cpl_status,
    input  logic [DW-1:0]     cpl_data,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] done_code,
    output logic [DW-1:0]     done_data,
    output logic              done_np
);

    pio_state_e state_q, state_d;
    logic       np_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch)    state_d = ST_ISSUE;
            ST_ISSUE: if (req_ready) state_d = ST_WAIT;
            ST_WAIT:  if (cpl_valid) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_type   <= '0;
            req_addr   <= '0;
            req_data   <= '0;
            req_strb   <= '0;
            req_bypass <= 1'b0;
            np_q       <= 1'b0;
        end else if (launch && state_q == ST_IDLE) begin
            req_type   <= in_type;
            req_bypass <= in_bypass;
            req_data   <= in_data;
            req_addr   <= is_cfg_type(in_type) ? {in_addr[AW-1:2], 2'b00} : in_addr;
            req_strb   <= is_cfg_read(in_type) ? '1 : in_strb;
            np_q       <= is_cfg_type(in_type);
        end
    end

    always_comb begin
        req_valid = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy      = 1'b0;
            ST_ISSUE: req_valid = 1'b1;
            ST_WAIT:  done      = cpl_valid;
            default:  busy      = 1'b0;
        endcase
    end

    assign done_code = cpl_status;
    assign done_data = cpl_data;
    assign done_np   = np_q;

endmodule

// File: rtl/pio_cfg_engine.sv
module pio_cfg_engine
    import pio_cfg_pkg::*;
#(
    parameter int DW = 32,
    localparam int SW = DW / 8,
    localparam int AW = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [TYPE_W-1:0] req_type,
    output logic [AW-1:0]     req_addr,
    output logic [DW-1:0]     req_data,
    output logic [SW-1:0]     req_strb,
    output logic              req_bypass,
    input  logic              cpl_valid,
    input  logic [CODE_W-1:0] cpl_status,
    input  logic [DW-1:0]     cpl_data,
    output logic              irq
);

    logic              launch, busy, done, done_np;
    logic [CODE_W-1:0] done_code;
    logic [DW-1:0]     done_data;
    logic [TYPE_W-1:0] ctrl_type;
    logic              ctrl_bypass;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q, rdata_q;
    logic [SW-1:0]     strb_q;
    logic              start_q, done_q;

    pio_cfg_regs #(.DW(DW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .idx         (cfg_idx),
        .wr_data     (cfg_wdata),
        .rd_data     (cfg_rdata),
        .busy        (busy),
        .done        (done),
        .done_code   (done_code),
        .done_data   (done_data),
        .done_np     (done_np),
        .launch      (launch),
        .ctrl_type   (ctrl_type),
        .ctrl_bypass (ctrl_bypass),
        .addr_q      (addr_q),
        .wdata_q     (wdata_q),
        .strb_q      (strb_q),
        .start_q     (start_q),
        .done_q      (done_q),
        .rdata_q     (rdata_q),
        .irq         (irq)
    );

    pio_cfg_fsm #(.DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .in_type    (ctrl_type),
        .in_bypass  (ctrl_bypass),
        .in_addr    (addr_q),
        .in_data    (wdata_q),
        .in_strb    (strb_q),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_type   (req_type),
        .req_addr   (req_addr),
        .req_data   (req_data),
        .req_strb   (req_strb),
        .req_bypass (req_bypass),
        .cpl_valid  (cpl_valid),
        .cpl_status (cpl_status),
        .cpl_data   (cpl_data),
        .busy       (busy),
        .done       (done),
        .done_code  (done_code),
        .done_data  (done_data),
        .done_np    (done_np)
    );

endmodule

// File: rtl/pio_cfg_engine_chk.sv
module pio_cfg_engine_chk
    import pio_cfg_pkg::*;
#(
    parameter int DW = 32,
    localparam int SW = DW / 8,
    localparam int AW = 2 * DW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [TYPE_W-1:0] req_type,
    input logic [AW-1:0]     req_addr,
    input logic [SW-1:0]     req_strb,
    input logic              done,
    input logic [CODE_W-1:0] cpl_status,
    input logic              start_q,
    input logic              done_q,
    input logic [DW-1:0]     rdata_q,
    input logic              irq
);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_type)); // R2

    AST_REQ_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> start_q); // R7

    AST_ALIGNED_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_type[3:2] == 2'b10 |-> req_addr[1:0] == 2'b00); // R3

    AST_READ_FULL_STRB: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_type[3:1] == 3'b100 |-> req_strb == '1); // R4

    AST_START_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_q) |-> done_q); // R5

    AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        done && cpl_status != CODE_OK |=> rdata_q == '1); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_q); // R9

endmodule

bind pio_cfg_engine pio_cfg_engine_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_type   (req_type),
    .req_addr   (req_addr),
    .req_strb   (req_strb),
    .done       (done),
    .cpl_status (cpl_status),
    .start_q    (start_q),
    .done_q     (done_q),
    .rdata_q    (rdata_q),
    .irq        (irq)
);

// File: tb/sim_pio_cfg_engine.sv
module sim_pio_cfg_engine;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [3:0]  typ;
        logic        byp;
        logic [31:0] alo;
        logic [31:0] ahi;
        logic [31:0] wd;
        logic [3:0]  st;
        logic [2:0]  cs;
        logic [31:0] cd;
        logic [1:0]  lat;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{4'h8, 1'b1, 32'h0012_3047, 32'h0000_0000, 32'h0000_0000, 4'h1, 3'd0, 32'hDEAD_BEEF, 2'd0},
        '{4'hA, 1'b0, 32'h0020_0106, 32'h0000_0000, 32'h1234_0000, 4'hC, 3'd0, 32'h0000_5555, 2'd1},
        '{4'h9, 1'b1, 32'h0150_8008, 32'h0000_0000, 32'h0000_0000, 4'h0, 3'd1, 32'h0BAD_0001, 2'd2},
        '{4'hB, 1'b0, 32'h0300_100D, 32'h0000_0000, 32'h0000_AB00, 4'h2, 3'd2, 32'h1111_2222, 2'd3},
        '{4'h9, 1'b0, 32'h0710_2FFC, 32'h0000_0000, 32'h0000_0000, 4'h3, 3'd4, 32'h3333_4444, 2'd1},
        '{4'h0, 1'b1, 32'h8000_0003, 32'h0000_0001, 32'hCAFE_F00D, 4'h3, 3'd0, 32'h7777_8888, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid, req_ready = 1'b0;
    logic [3:0]  req_type;
    logic [63:0] req_addr;
    logic [31:0] req_data;
    logic [3:0]  req_strb;
    logic        req_bypass;
    logic        cpl_valid = 1'b0;
    logic [2:0]  cpl_status = '0;
    logic [31:0] cpl_data = '0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio_cfg_engine u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_addr(req_addr), .req_data(req_data), .req_strb(req_strb),
        .req_bypass(req_bypass), .cpl_valid(cpl_valid), .cpl_status(cpl_status),
        .cpl_data(cpl_data), .irq(irq)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_run();
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] val);
        cfg_idx = idx;
        #1;
        val = cfg_rdata;
    endtask

    // Accept after lat cycles, then return one completion.
    task automatic respond(input logic [1:0] lat, input logic [2:0] cs, input logic [31:0] cd);
        for (int k = 0; k < int'(lat); k++) begin
            chk("R2 valid held before accept", {63'd0, req_valid}, 64'd1);
            @(negedge clk);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk("R2 single request, valid drops", {63'd0, req_valid}, 64'd0);
        cpl_valid = 1'b1; cpl_status = cs; cpl_data = cd;
        @(negedge clk);
        cpl_valid = 1'b0; cpl_status = '0; cpl_data = '0;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        for (int i = 0; i < 10; i++) begin
            rd(4'(i), v);
            chk($sformatf("R1 reg %0d after reset", i), {32'd0, v}, 64'd0);
        end
        chk("R1 no request after reset", {63'd0, req_valid}, 64'd0);
        chk("R1 irq low after reset", {63'd0, irq}, 64'd0);

        // Table of requests
        for (int i = 0; i < NVEC; i++) begin
            vec_t t = VECS[i];
            logic        cfgt = (t.typ[3:2] == 2'b10);
            logic [63:0] ea   = {t.ahi, t.alo};
            logic [3:0]  es   = (t.typ == 4'h8 || t.typ == 4'h9) ? 4'hF : t.st;
            logic [31:0] erd  = (t.cs == 3'd0) ? t.cd : 32'hFFFF_FFFF;
            if (cfgt) ea[1:0] = 2'b00;
            wr(4'd0, {7'd0, t.byp, 20'd0, t.typ});
            wr(4'd2, t.alo);
            wr(4'd3, t.ahi);
            wr(4'd4, t.wd);
            wr(4'd5, {28'd0, t.st});
            wr(4'd7, 32'd0);
            wr(4'd8, 32'd1);
            wr(4'd7, 32'd1);
            chk($sformatf("R2 vec%0d request raised", i), {63'd0, req_valid}, 64'd1);
            chk($sformatf("R3 vec%0d type", i), {60'd0, req_type}, {60'd0, t.typ});
            chk($sformatf("R3 vec%0d bypass", i), {63'd0, req_bypass}, {63'd0, t.byp});
            chk($sformatf("R10 vec%0d address", i), req_addr, ea);
            chk($sformatf("R2 vec%0d data", i), {32'd0, req_data}, {32'd0, t.wd});
            chk($sformatf("R4 vec%0d strobe", i), {60'd0, req_strb}, {60'd0, es});
            respond(t.lat, t.cs, t.cd);
            rd(4'd7, v); chk($sformatf("R5 vec%0d start cleared", i), {32'd0, v}, 64'd0);
            rd(4'd8, v); chk($sformatf("R5 vec%0d done flag", i), {32'd0, v}, 64'd1);
            rd(4'd1, v); chk($sformatf("R5 vec%0d status", i), {32'd0, v},
                             {32'd0, 22'd0, t.cs, 6'd0, cfgt});
            rd(4'd6, v); chk($sformatf("R6 vec%0d read data", i), {32'd0, v}, {32'd0, erd});
            chk($sformatf("R9 vec%0d irq unmasked", i), {63'd0, irq}, 64'd1);
        end

        // Start writes while a request is outstanding
        wr(4'd8, 32'd1);
        wr(4'd0, 32'h8);
        wr(4'd7, 32'd1);
        wr(4'd7, 32'd1);
        wr(4'd7, 32'd0);
        rd(4'd7, v); chk("R7 start kept during flight", {32'd0, v}, 64'd1);
        chk("R7 original request still valid", {63'd0, req_valid}, 64'd1);
        respond(2'd0, 3'd0, 32'h0000_0042);
        for (int k = 0; k < 4; k++) begin
            chk("R7 no second request", {63'd0, req_valid}, 64'd0);
            @(negedge clk);
        end
        rd(4'd7, v); chk("R7 start reads 0 after completion", {32'd0, v}, 64'd0);

        // Mask and write-one-to-clear
        wr(4'd9, 32'd1);
        wr(4'd8, 32'd1);
        wr(4'd0, 32'hA);
        wr(4'd7, 32'd1);
        respond(2'd1, 3'd0, 32'h0);
        rd(4'd8, v); chk("R9 flag set while masked", {32'd0, v}, 64'd1);
        chk("R9 irq suppressed by mask", {63'd0, irq}, 64'd0);
        wr(4'd9, 32'd0);
        chk("R9 irq after unmask", {63'd0, irq}, 64'd1);
        wr(4'd8, 32'd0);
        rd(4'd8, v); chk("R8 write 0 leaves flag", {32'd0, v}, 64'd1);
        wr(4'd8, 32'd1);
        rd(4'd8, v); chk("R8 write 1 clears flag", {32'd0, v}, 64'd0);
        chk("R9 irq low after clear", {63'd0, irq}, 64'd0);

        finish_run();
    end

endmodule